// File: doc/BRIEF.md
# Two-Register I2C Command Write Slave

This block receives configuration writes from an I2C-compatible bus master into two 8-bit command registers. It controls an audio path: volume, input source selection, software enable, maximum-gain code and beep attenuation code. A system clock much faster than SCL oversamples both bus lines. Each line passes through a two-flop synchronizer and a glitch filter. Edge logic then finds START, repeated START and STOP conditions.

A frame opens with an address byte. The slave acknowledges it only when the upper seven bits equal `101000` followed by the level of the address-select strap, and the R/W bit is 0. No register-pointer byte follows. The first data byte always targets command register 0 and a second data byte targets command register 1, so register 1 can only be written after register 0 in the same frame. Every data byte is committed only once its acknowledge clock has ended. Read-back and clock stretching are not provided.

Top module: `cmd_reg_i2c_slave`

## Requirements
- R1: While rst_ni is low, and after it is released, both command registers and every decoded field read 0, and sda_oe_o is 0.
- R2: An address byte whose bits [7:1] equal {6'b101000, addr_sel_i} and whose bit 0 is 0 (write) is acknowledged. The slave sets sda_oe_o to 1 (pulling SDA low) during the whole high phase of the ninth SCL clock.
- R3: An address byte that does not match, or that has bit 0 set to 1 (read), gets no acknowledge. The bytes that follow it in the same frame get no acknowledge and change no register.
- R4: The first data byte after an acknowledged address is stored in register 0 (reg0_o) and the second in register 1 (reg1_o). Each is stored only after the SCL falling edge that ends its acknowledge clock. A frame with one data byte leaves register 1 unchanged.
- R5: Data bytes after the second in one frame are not acknowledged, and both registers keep their values.
- R6: A STOP at any point aborts the frame. A byte that was only partly received is discarded.
- R7: A STOP that occurs in the same SCL-high interval as the START before it is ignored, and the frame continues with the address phase.
- R8: A repeated START begins a new address phase, and the next data byte goes to register 0 again.
- R9: The decoded fields come from fixed bit positions. Register 0 bit 7 is the enable, bits [6:5] the source and bits [4:0] the volume. Register 1 bits [2:0] are the gain code and bits [7:5] the beep attenuation code.
- R10: The slave ignores a pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks. Such a pulse adds no bit and creates no START or STOP.
- R11: Writes are accepted while the enable bit (register 0 bit 7) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System oversampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Strap giving the address LSB |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| reg0_o | output | 8 | Command register 0 |
| reg1_o | output | 8 | Command register 1 |
| volume_o | output | 5 | Volume code, reg0[4:0] |
| source_o | output | 2 | Input source code, reg0[6:5] |
| enable_o | output | 1 | Software enable, reg0[7] |
| gain_code_o | output | 3 | Maximum-gain code, reg1[2:0] |
| beep_atten_o | output | 3 | Beep attenuation code, reg1[7:5] |

## Verification
Two situations are hard to reach from the ports. The first is a STOP inside the same SCL-high interval as its START. The bench drops SDA and then raises it again while holding SCL high. It then clocks a full address and data byte, and the register update shows that the frame survived. The second is a glitch shorter than the filter window. During every high phase of one byte, the bench dips SCL and flips SDA for a single system clock. A correct register value then shows that no bit was gained and no frame was aborted.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam int REG_COUNT = 2;
  localparam logic [5:0] DEV_ADDR_HI = 6'b101000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_IGNORE
  } slv_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == out_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        out_q <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = out_q;

  // filtered level only moves to a level the synchronizer already holds
  assert_filter_follows_sync_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_q) |-> ($past(sync_q[1]) == out_q));
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q, start_hi_q;
  logic raw_stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      start_hi_q <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_o)         start_hi_q <= 1'b1;
      else if (scl_fall_o) start_hi_q <= 1'b0;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign raw_stop   = scl_i & scl_q & ~sda_q & sda_i;
  // a STOP in the START's own high interval is not honoured
  assign stop_o     = raw_stop & ~start_hi_q;

  assert_start_window_closed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_rise_o |-> !start_hi_q);
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_cmd_pkg::*;
#(
  parameter int NUM_REGS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_rise_i,
  input  logic                 scl_fall_i,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic                 sda_i,
  input  logic                 addr_sel_i,
  output logic                 sda_oe_o,
  output logic                 wr_en_o,
  output logic [((NUM_REGS > 1) ? $clog2(NUM_REGS) : 1)-1:0] wr_idx_o,
  output logic [7:0]           wr_data_o
);
  localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int IW = $clog2(NUM_REGS + 1);

  slv_state_e    state_q;
  logic [3:0]    bit_cnt_q;
  logic [7:0]    shift_q;
  logic [IW-1:0] byte_idx_q;
  logic          addr_hit;

  assign addr_hit = (shift_q[7:1] == {DEV_ADDR_HI, addr_sel_i}) && !shift_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      shift_q    <= '0;
      byte_idx_q <= '0;
      sda_oe_o   <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_idx_o   <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        state_q    <= ST_ADDR;
        bit_cnt_q  <= '0;
        byte_idx_q <= '0;
        sda_oe_o   <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_DATA: begin
            if (scl_rise_i && bit_cnt_q < 4'd8) begin
              shift_q   <= {shift_q[6:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
              if (state_q == ST_ADDR) begin
                if (addr_hit) begin
                  state_q  <= ST_ADDR_ACK;
                  sda_oe_o <= 1'b1;
                end else begin
                  state_q <= ST_IGNORE;
                end
              end else if (byte_idx_q < IW'(NUM_REGS)) begin
                state_q  <= ST_DATA_ACK;
                sda_oe_o <= 1'b1;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o  <= 1'b0;
              state_q   <= ST_DATA;
              bit_cnt_q <= '0;
            end
          end
          ST_DATA_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o   <= 1'b0;
              state_q    <= ST_DATA;
              bit_cnt_q  <= '0;
              wr_en_o    <= 1'b1;
              wr_idx_o   <= byte_idx_q[AW-1:0];
              wr_data_o  <= shift_q;
              byte_idx_q <= byte_idx_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_ack_starts_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall_i));

  assert_no_ack_while_ignoring_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IGNORE) |-> !sda_oe_o);

  assert_commit_follows_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(sda_oe_o));

  assert_extra_byte_nack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_idx_q == IW'(NUM_REGS)) |-> !sda_oe_o);

  assert_stop_releases_sda_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (state_q == ST_IDLE) && !sda_oe_o);
endmodule

// File: rtl/cmd_reg_i2c_slave.sv
module cmd_reg_i2c_slave
  import i2c_cmd_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_sel_i,
  output logic       sda_oe_o,
  output logic [7:0] reg0_o,
  output logic [7:0] reg1_o,
  output logic [4:0] volume_o,
  output logic [1:0] source_o,
  output logic       enable_o,
  output logic [2:0] gain_code_o,
  output logic [2:0] beep_atten_o
);
  localparam int AW = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

  logic [1:0] raw_lines, filt_lines;
  logic       scl_rise, scl_fall, start_cond, stop_cond;
  logic          wr_en;
  logic [AW-1:0] wr_idx;
  logic [7:0]    wr_data;
  logic [7:0]    regs_q [REG_COUNT];

  assign raw_lines = {scl_i, sda_i};

  for (genvar l = 0; l < 2; l++) begin : g_line
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw_lines[l]),
      .line_o (filt_lines[l])
    );
  end

  i2c_cond_detect u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (filt_lines[1]),
    .sda_i      (filt_lines[0]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_cond),
    .stop_o     (stop_cond)
  );

  i2c_byte_engine #(.NUM_REGS(REG_COUNT)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_cond),
    .stop_i     (stop_cond),
    .sda_i      (filt_lines[0]),
    .addr_sel_i (addr_sel_i),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data)
  );

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        regs_q[g] <= '0;
      else if (wr_en && wr_idx == AW'(g)) regs_q[g] <= wr_data;
    end

    assert_reg_only_on_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(regs_q[g]) |-> $past(wr_en && wr_idx == AW'(g)));
  end

  assign reg0_o       = regs_q[0];
  assign reg1_o       = regs_q[1];
  assign enable_o     = regs_q[0][7];
  assign source_o     = regs_q[0][6:5];
  assign volume_o     = regs_q[0][4:0];
  assign gain_code_o  = regs_q[1][2:0];
  assign beep_atten_o = regs_q[1][7:5];
endmodule

// File: tb/cmd_reg_i2c_slave_tb_top.sv
module cmd_reg_i2c_slave_tb_top;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic addr_sel = 1'b0;
  logic sda_line;
  logic       sda_oe;
  logic [7:0] reg0, reg1;
  logic [4:0] volume;
  logic [1:0] source;
  logic       enable;
  logic [2:0] gain_code, beep_atten;

  int cyc = 0;
  int hold_until = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_r0 = 8'h00;
  logic [7:0] exp_r1 = 8'h00;

  always #2.5 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  cmd_reg_i2c_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_sel_i(addr_sel), .sda_oe_o(sda_oe), .reg0_o(reg0), .reg1_o(reg1),
    .volume_o(volume), .source_o(source), .enable_o(enable),
    .gain_code_o(gain_code), .beep_atten_o(beep_atten)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // per-clock comparison against the behavioural model (R4, R9)
  always @(negedge clk) begin
    if (rst_n && !done && cyc >= hold_until) begin
      check(reg0 == exp_r0, "R4", "reg0", 32'(reg0), 32'(exp_r0));
      check(reg1 == exp_r1, "R4", "reg1", 32'(reg1), 32'(exp_r1));
      check({enable, source, volume} == exp_r0, "R9", "reg0 fields",
            32'({enable, source, volume}), 32'(exp_r0));
      check({beep_atten, gain_code} == {exp_r1[7:5], exp_r1[2:0]}, "R9", "reg1 fields",
            32'({beep_atten, gain_code}), 32'({exp_r1[7:5], exp_r1[2:0]}));
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    m_sda = b; tick(Q); scl = 1'b1; tick(Q);
    if (glitch) begin
      scl = 1'b0; tick(1); scl = 1'b1; tick(2);
      m_sda = ~b; tick(1); m_sda = b;
    end
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic want_ack, input bit glitch,
                           input string req);
    for (int i = 7; i >= 0; i--) send_bit(b[i], glitch);
    m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    check(sda_oe == want_ack, req, "ack", 32'(sda_oe), 32'(want_ack));
    tick(Q); scl = 1'b0;
    hold_until = cyc + Q + 4;
    tick(Q);
  endtask

  initial begin
    tick(5);
    check(reg0 == 8'h00 && reg1 == 8'h00 && sda_oe == 1'b0, "R1", "reset in",
          32'({reg0, reg1, 7'd0, sda_oe}), 32'h0);
    rst_n = 1'b1;
    tick(5);
    check({reg0, reg1, enable, source, volume, gain_code, beep_atten, sda_oe} == '0,
          "R1", "after reset", 32'({reg0, reg1}), 32'h0);

    // R2 R4 R11: two-byte frame with enable bit clear
    bus_start();
    send_byte(8'hA0, 1'b1, 1'b0, "R2");
    send_byte(8'h1F, 1'b1, 1'b0, "R11"); exp_r0 = 8'h1F;
    send_byte(8'h85, 1'b1, 1'b0, "R4");  exp_r1 = 8'h85;
    bus_stop();
    check(gain_code == 3'd5 && beep_atten == 3'd4, "R9", "gain/beep",
          32'({gain_code, beep_atten}), 32'({3'd5, 3'd4}));
    check(enable == 1'b0 && volume == 5'h1F, "R11", "write while disabled",
          32'({enable, volume}), 32'({1'b0, 5'h1F}));

    // R4: single-byte frame leaves reg1
    bus_start();
    send_byte(8'hA0, 1'b1, 1'b0, "R2");
    send_byte(8'hC9, 1'b1, 1'b0, "R4"); exp_r0 = 8'hC9;
    bus_stop();
    check(reg1 == 8'h85, "R4", "reg1 kept", 32'(reg1), 32'h85);
    check(enable && source == 2'd2 && volume == 5'd9, "R9", "reg0 fields",
          32'({enable, source, volume}), 32'({1'b1, 2'd2, 5'd9}));

    // R5: third byte refused
    bus_start();
    send_byte(8'hA0, 1'b1, 1'b0, "R2");
    send_byte(8'h11, 1'b1, 1'b0, "R4"); exp_r0 = 8'h11;
    send_byte(8'h22, 1'b1, 1'b0, "R4"); exp_r1 = 8'h22;
    send_byte(8'h33, 1'b0, 1'b0, "R5");
    send_byte(8'h44, 1'b0, 1'b0, "R5");
    bus_stop();

    // R3: wrong address and read request
    bus_start();
    send_byte(8'hA2, 1'b0, 1'b0, "R3");
    send_byte(8'h55, 1'b0, 1'b0, "R3");
    bus_stop();
    bus_start();
    send_byte(8'hA1, 1'b0, 1'b0, "R3");
    send_byte(8'h56, 1'b0, 1'b0, "R3");
    bus_stop();

    // R2: strap selects address LSB
    addr_sel = 1'b1;
    tick(Q);
    bus_start();
    send_byte(8'hA0, 1'b0, 1'b0, "R2");
    bus_stop();
    bus_start();
    send_byte(8'hA2, 1'b1, 1'b0, "R2");
    send_byte(8'h66, 1'b1, 1'b0, "R4"); exp_r0 = 8'h66;
    bus_stop();

    // R6: stop inside a data byte
    bus_start();
    send_byte(8'hA2, 1'b1, 1'b0, "R2");
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
    bus_stop();
    tick(Q);
    check(reg0 == 8'h66, "R6", "partial byte dropped", 32'(reg0), 32'h66);

    // R8: repeated start restarts at register 0
    bus_start();
    send_byte(8'hA2, 1'b1, 1'b0, "R2");
    send_byte(8'h3C, 1'b1, 1'b0, "R8"); exp_r0 = 8'h3C;
    bus_rstart();
    send_byte(8'hA2, 1'b1, 1'b0, "R8");
    send_byte(8'h5A, 1'b1, 1'b0, "R8"); exp_r0 = 8'h5A;
    bus_stop();
    check(reg0 == 8'h5A && reg1 == 8'h22, "R8", "rstart regs",
          32'({reg0, reg1}), 32'h5A22);

    // R7: stop in the start's own high interval is ignored
    m_sda = 1'b0; tick(Q); m_sda = 1'b1; tick(Q); scl = 1'b0; tick(Q);
    send_byte(8'hA2, 1'b1, 1'b0, "R7");
    send_byte(8'h42, 1'b1, 1'b0, "R7"); exp_r0 = 8'h42;
    bus_stop();
    check(reg0 == 8'h42, "R7", "frame continued", 32'(reg0), 32'h42);

    // R10: single-clock glitches on both lines in every high phase
    bus_start();
    send_byte(8'hA2, 1'b1, 1'b1, "R10");
    send_byte(8'h99, 1'b1, 1'b1, "R10"); exp_r0 = 8'h99;
    bus_stop();
    tick(Q);
    check(reg0 == 8'h99, "R10", "glitch filtered", 32'(reg0), 32'h99);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule